// File: doc/BRIEF.md
# End-of-Interrupt Register Write Permission Gate

This block sits beside the system-register access path of a processor core. It judges one software write to the group 0 end-of-interrupt register. It first checks the five instruction encoding fields. When they match, it runs a fixed-priority chain of conditions to choose one outcome:

- undefined instruction,
- trap to a target exception level,
- redirect to the virtual copy of the register,
- normal write.

The order of the chain depends on the exception level that issues the access. The inputs are the exception level, whether the feature is present, the per-level register-access enable bits, the hypervisor trap and interrupt-routing bits, the monitor's interrupt-routing bit and two secure-debug conditions.

A request is taken on a valid strobe. The decision is held in registers and appears one clock later with its own valid. An access whose encoding does not match gives no response. Performing the write and entering the exception belong to other blocks.

Top module: `eoi_access_gate`

## Requirements
- R1: A request is recognised only when op0=2'b11, op1=3'b000, crn=4'b1100, crm=4'b1000 and op2=3'b001. For any other encoding, or with `req_valid` low, the next cycle shows `rsp_valid`=0 and `rsp_outcome`=0.
- R2: A recognised request gives `rsp_valid`=1 exactly one clock later. After a synchronous reset, `rsp_valid`, `rsp_outcome`, `rsp_target_el` and `rsp_ec` are all zero.
- R3: If `feat_present` is 0, or `cur_el` is 0, the outcome is undefined. This holds at every level.
- R4: At `cur_el`=1 the first matching rule wins, in this order:
  1. `el3_present & sdd_undef_prio & mon_fiq_route` gives undefined.
  2. `acc_en_el1`=0 gives a trap to level 1.
  3. `el2_enabled & hyp_trap_g0` gives a trap to level 2.
  4. `el2_enabled & hyp_fiq_route` gives a redirect to the virtual register.
  5. `el3_present & mon_fiq_route` gives undefined if `sdd_undef` is 1, else a trap to level 3.
  6. Otherwise the outcome is a normal write.
- R5: At `cur_el`=2 the first matching rule wins, in this order:
  1. The same undefined-priority rule as R4.
  2. `acc_en_el2`=0 gives a trap to level 2.
  3. `el3_present & mon_fiq_route` gives undefined if `sdd_undef` is 1, else a trap to level 3.
  4. Otherwise the outcome is a normal write.
  
  A redirect never happens at level 2.
- R6: At `cur_el`=3, `acc_en_el3`=0 gives a trap to level 3. Otherwise the outcome is a normal write.
- R7: A trap reports `rsp_ec`=6'h18 and `rsp_target_el` equal to the level it traps to. Every other outcome reports `rsp_target_el`=0 and `rsp_ec`=0.
- R8: `rsp_outcome` is {undef, trap, virt, write}, with bit 3 as undef and bit 0 as write. Exactly one bit is set while `rsp_valid` is 1, and no bit is set otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| op0 | input | 2 | Encoding field op0 |
| op1 | input | 3 | Encoding field op1 |
| crn | input | 4 | Encoding field CRn |
| crm | input | 4 | Encoding field CRm |
| op2 | input | 3 | Encoding field op2 |
| cur_el | input | 2 | Exception level issuing the access |
| feat_present | input | 1 | Interrupt controller register interface implemented |
| el3_present | input | 1 | Level 3 implemented |
| el2_enabled | input | 1 | Level 2 enabled for the current state |
| acc_en_el1 | input | 1 | Register-interface enable for level 1 |
| acc_en_el2 | input | 1 | Register-interface enable for level 2 |
| acc_en_el3 | input | 1 | Register-interface enable for level 3 |
| hyp_trap_g0 | input | 1 | Hypervisor traps all group 0 register accesses |
| hyp_fiq_route | input | 1 | Hypervisor routes FIQ to level 2 |
| mon_fiq_route | input | 1 | Monitor routes FIQ to level 3 |
| sdd_undef_prio | input | 1 | Secure-debug condition that makes undefined take priority |
| sdd_undef | input | 1 | Secure-debug condition that turns a level 3 trap into undefined |
| rsp_valid | output | 1 | Decision valid, one cycle after a recognised request |
| rsp_outcome | output | 4 | One-hot {undef, trap, virt, write} |
| rsp_target_el | output | 2 | Trap target level, 0 if not a trap |
| rsp_ec | output | 6 | Syndrome exception class, 0x18 on a trap |

## Verification
The hardest cases to reach are the deep rules of the level 1 chain. The redirect and the trap-or-undefined choice at level 3 only show when every higher rule is inactive, yet the inputs those higher rules read must still be set to the right values. The bench does not aim at these cases one by one. It sweeps all 2048 settings of the eleven control inputs at each of the four levels, so every rule is reached both as the winner and as the loser to each earlier rule. A single-bit flip of each encoding field covers the near-miss encodings.

// File: rtl/eoi_acc_pkg.sv
package eoi_acc_pkg;
  localparam int EL_W = 2;
  localparam int EC_W = 6;

  typedef struct packed {
    logic undef;
    logic trap;
    logic virt;
    logic wr;
    logic [EL_W-1:0] tgt;
  } eoi_dec_t;

  typedef struct packed {
    logic feat;
    logic el3_has;
    logic el2_on;
    logic en_el1;
    logic en_el2;
    logic en_el3;
    logic hyp_tg0;
    logic hyp_fiq;
    logic mon_fiq;
    logic sdd_prio;
    logic sdd_undef;
  } eoi_ctl_t;

  function automatic eoi_dec_t dec_undef();
    eoi_dec_t d;
    d = '0;
    d.undef = 1'b1;
    return d;
  endfunction

  function automatic eoi_dec_t dec_trap(input logic [EL_W-1:0] lvl);
    eoi_dec_t d;
    d = '0;
    d.trap = 1'b1;
    d.tgt  = lvl;
    return d;
  endfunction

  function automatic eoi_dec_t dec_virt();
    eoi_dec_t d;
    d = '0;
    d.virt = 1'b1;
    return d;
  endfunction

  function automatic eoi_dec_t dec_write();
    eoi_dec_t d;
    d = '0;
    d.wr = 1'b1;
    return d;
  endfunction
endpackage

// File: rtl/eoi_enc_match.sv
module eoi_enc_match #(
  parameter logic [1:0] OP0 = 2'b11,
  parameter logic [2:0] OP1 = 3'b000,
  parameter logic [3:0] CRN = 4'b1100,
  parameter logic [3:0] CRM = 4'b1000,
  parameter logic [2:0] OP2 = 3'b001
) (
  input  logic [1:0] op0,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output logic       hit
);
  localparam int ENC_W = 16;
  localparam logic [ENC_W-1:0] ENC_REF = {OP0, OP1, CRN, CRM, OP2};

  logic [ENC_W-1:0] enc;

  always_comb begin
    enc = {op0, op1, crn, crm, op2};
    hit = (enc == ENC_REF);
  end
endmodule

// File: rtl/eoi_rule_eval.sv
module eoi_rule_eval
  import eoi_acc_pkg::*;
#(
  parameter int LEVEL = 1
) (
  input  eoi_ctl_t ctl,
  output eoi_dec_t dec
);
  localparam logic [EL_W-1:0] TGT_L1 = EL_W'(1);
  localparam logic [EL_W-1:0] TGT_L2 = EL_W'(2);
  localparam logic [EL_W-1:0] TGT_L3 = EL_W'(3);

  logic undef_first;
  logic mon_route;

  always_comb begin
    undef_first = ctl.el3_has & ctl.sdd_prio & ctl.mon_fiq;
    mon_route   = ctl.el3_has & ctl.mon_fiq;
  end

  generate
    if (LEVEL == 1) begin : g_l1
      always_comb begin
        if (!ctl.feat)                      dec = dec_undef();
        else if (undef_first)               dec = dec_undef();
        else if (!ctl.en_el1)               dec = dec_trap(TGT_L1);
        else if (ctl.el2_on && ctl.hyp_tg0) dec = dec_trap(TGT_L2);
        else if (ctl.el2_on && ctl.hyp_fiq) dec = dec_virt();
        else if (mon_route)                 dec = ctl.sdd_undef ? dec_undef() : dec_trap(TGT_L3);
        else                                dec = dec_write();
      end
    end else if (LEVEL == 2) begin : g_l2
      always_comb begin
        if (!ctl.feat)          dec = dec_undef();
        else if (undef_first)   dec = dec_undef();
        else if (!ctl.en_el2)   dec = dec_trap(TGT_L2);
        else if (mon_route)     dec = ctl.sdd_undef ? dec_undef() : dec_trap(TGT_L3);
        else                    dec = dec_write();
      end
    end else if (LEVEL == 3) begin : g_l3
      always_comb begin
        if (!ctl.feat)          dec = dec_undef();
        else if (!ctl.en_el3)   dec = dec_trap(TGT_L3);
        else                    dec = dec_write();
      end
    end else begin : g_l0
      always_comb dec = dec_undef();
    end
  endgenerate
endmodule

// File: rtl/eoi_dec_reg.sv
module eoi_dec_reg
  import eoi_acc_pkg::*;
#(
  parameter int             ECW     = EC_W,
  parameter logic [ECW-1:0] TRAP_EC = ECW'(8'h18)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  eoi_dec_t        in_dec,
  output logic            out_valid,
  output logic [3:0]      out_outcome,
  output logic [EL_W-1:0] out_tgt,
  output logic [ECW-1:0]  out_ec
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_outcome <= '0;
      out_tgt     <= '0;
      out_ec      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_outcome <= {in_dec.undef, in_dec.trap, in_dec.virt, in_dec.wr};
        out_tgt     <= in_dec.trap ? in_dec.tgt : '0;
        out_ec      <= in_dec.trap ? TRAP_EC : '0;
      end else begin
        out_outcome <= '0;
        out_tgt     <= '0;
        out_ec      <= '0;
      end
    end
  end
endmodule

// File: rtl/eoi_access_gate.sv
module eoi_access_gate
  import eoi_acc_pkg::*;
#(
  parameter int NUM_EL = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [1:0]      op0,
  input  logic [2:0]      op1,
  input  logic [3:0]      crn,
  input  logic [3:0]      crm,
  input  logic [2:0]      op2,
  input  logic [EL_W-1:0] cur_el,
  input  logic            feat_present,
  input  logic            el3_present,
  input  logic            el2_enabled,
  input  logic            acc_en_el1,
  input  logic            acc_en_el2,
  input  logic            acc_en_el3,
  input  logic            hyp_trap_g0,
  input  logic            hyp_fiq_route,
  input  logic            mon_fiq_route,
  input  logic            sdd_undef_prio,
  input  logic            sdd_undef,
  output logic            rsp_valid,
  output logic [3:0]      rsp_outcome,
  output logic [EL_W-1:0] rsp_target_el,
  output logic [EC_W-1:0] rsp_ec
);
  logic     enc_hit;
  eoi_ctl_t ctl;
  eoi_dec_t lvl_dec [NUM_EL];
  eoi_dec_t sel_dec;

  eoi_enc_match u_match (
    .op0 (op0),
    .op1 (op1),
    .crn (crn),
    .crm (crm),
    .op2 (op2),
    .hit (enc_hit)
  );

  always_comb begin
    ctl.feat      = feat_present;
    ctl.el3_has   = el3_present;
    ctl.el2_on    = el2_enabled;
    ctl.en_el1    = acc_en_el1;
    ctl.en_el2    = acc_en_el2;
    ctl.en_el3    = acc_en_el3;
    ctl.hyp_tg0   = hyp_trap_g0;
    ctl.hyp_fiq   = hyp_fiq_route;
    ctl.mon_fiq   = mon_fiq_route;
    ctl.sdd_prio  = sdd_undef_prio;
    ctl.sdd_undef = sdd_undef;
  end

  for (genvar g = 0; g < NUM_EL; g++) begin : g_lvl
    eoi_rule_eval #(.LEVEL(g)) u_eval (
      .ctl (ctl),
      .dec (lvl_dec[g])
    );
  end

  always_comb sel_dec = lvl_dec[cur_el];

  eoi_dec_reg u_reg (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (req_valid & enc_hit),
    .in_dec      (sel_dec),
    .out_valid   (rsp_valid),
    .out_outcome (rsp_outcome),
    .out_tgt     (rsp_target_el),
    .out_ec      (rsp_ec)
  );
endmodule

// File: rtl/eoi_access_gate_chk.sv
module eoi_access_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [1:0] op0,
  input logic [2:0] op1,
  input logic [3:0] crn,
  input logic [3:0] crm,
  input logic [2:0] op2,
  input logic [1:0] cur_el,
  input logic       feat_present,
  input logic       rsp_valid,
  input logic [3:0] rsp_outcome,
  input logic [1:0] rsp_target_el,
  input logic [5:0] rsp_ec
);
  logic enc_ok;
  always_comb enc_ok = (op0 == 2'b11) && (op1 == 3'b000) && (crn == 4'b1100)
                       && (crm == 4'b1000) && (op2 == 3'b001);

  AST_NO_RSP_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    (!req_valid || !enc_ok) |=> (!rsp_valid && rsp_outcome == 4'b0)); // R1

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    (req_valid && enc_ok) |=> rsp_valid); // R2

  AST_LOW_LEVEL_UNDEF: assert property (@(posedge clk) disable iff (rst)
    (req_valid && enc_ok && (cur_el == 2'd0 || !feat_present)) |=> rsp_outcome == 4'b1000); // R3

  AST_L2_NO_VIRT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && enc_ok && cur_el == 2'd2) |=> !rsp_outcome[1]); // R5

  AST_L3_ONLY_TRAP3_OR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && enc_ok && cur_el == 2'd3 && feat_present) |=>
      (rsp_outcome == 4'b0001 || (rsp_outcome == 4'b0100 && rsp_target_el == 2'd3))); // R6

  AST_TRAP_SYNDROME: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_outcome[2]) |-> (rsp_ec == 6'h18 && rsp_target_el != 2'd0)); // R7

  AST_NONTRAP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rsp_outcome[2] |-> (rsp_ec == 6'h0 && rsp_target_el == 2'd0)); // R7

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones(rsp_outcome) == 1); // R8
endmodule

bind eoi_access_gate eoi_access_gate_chk u_chk (.*);

// File: tb/tb_eoi_access_gate.sv
module tb_eoi_access_gate;
  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid;
  logic [1:0] op0;
  logic [2:0] op1;
  logic [3:0] crn;
  logic [3:0] crm;
  logic [2:0] op2;
  logic [1:0] cur_el;
  logic [10:0] cv;
  logic       rsp_valid;
  logic [3:0] rsp_outcome;
  logic [1:0] rsp_target_el;
  logic [5:0] rsp_ec;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  eoi_access_gate dut (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .op0(op0), .op1(op1), .crn(crn), .crm(crm), .op2(op2),
    .cur_el(cur_el),
    .feat_present(cv[0]), .el3_present(cv[1]), .el2_enabled(cv[2]),
    .acc_en_el1(cv[3]), .acc_en_el2(cv[4]), .acc_en_el3(cv[5]),
    .hyp_trap_g0(cv[6]), .hyp_fiq_route(cv[7]), .mon_fiq_route(cv[8]),
    .sdd_undef_prio(cv[9]), .sdd_undef(cv[10]),
    .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome),
    .rsp_target_el(rsp_target_el), .rsp_ec(rsp_ec)
  );

  // Expected response {valid, outcome[3:0], target[1:0], ec[5:0]}
  function automatic logic [12:0] model(input logic [1:0] el, input logic [10:0] c);
    logic f, h3, e2, s1, s2, s3, tg, hf, mf, dp, du;
    logic [3:0] oc;
    logic [1:0] tl;
    {du, dp, mf, hf, tg, s3, s2, s1, e2, h3, f} = c;
    tl = 2'd0;
    if (!f || el == 2'd0) oc = 4'b1000;
    else if (el == 2'd3) begin
      if (!s3) begin oc = 4'b0100; tl = 2'd3; end else oc = 4'b0001;
    end else if (h3 && dp && mf) oc = 4'b1000;
    else if (el == 2'd1 && !s1) begin oc = 4'b0100; tl = 2'd1; end
    else if (el == 2'd2 && !s2) begin oc = 4'b0100; tl = 2'd2; end
    else if (el == 2'd1 && e2 && tg) begin oc = 4'b0100; tl = 2'd2; end
    else if (el == 2'd1 && e2 && hf) oc = 4'b0010;
    else if (h3 && mf) begin
      if (du) oc = 4'b1000; else begin oc = 4'b0100; tl = 2'd3; end
    end else oc = 4'b0001;
    return {1'b1, oc, tl, (oc == 4'b0100) ? 6'h18 : 6'h0};
  endfunction

  task automatic check(input string tag, input logic [12:0] exp);
    logic [12:0] act;
    act = {rsp_valid, rsp_outcome, rsp_target_el, rsp_ec};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s el=%0d ctl=%b act=%h exp=%h", tag, cur_el, cv, act, exp);
    end
  endtask

  task automatic set_enc(input logic [15:0] e);
    {op0, op1, crn, crm, op2} = e;
  endtask

  localparam logic [15:0] ENC_OK = {2'b11, 3'b000, 4'b1100, 4'b1000, 3'b001};

  initial begin
    rst = 1'b1; req_valid = 1'b0; cur_el = 2'd0; cv = '0;
    set_enc(ENC_OK);
    repeat (3) @(negedge clk);
    check("R2 reset state", 13'h0);
    rst = 1'b0;
    @(negedge clk);

    // Exhaustive sweep: every level with every control setting (R3..R8)
    for (int el = 0; el < 4; el++) begin
      for (int v = 0; v < 2048; v++) begin
        cur_el = el[1:0]; cv = v[10:0]; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (el == 0)      check("R3 level0", model(cur_el, cv));
        else if (el == 1) check("R4 R7 R8 level1 chain", model(cur_el, cv));
        else if (el == 2) check("R5 R7 R8 level2 chain", model(cur_el, cv));
        else              check("R6 R7 R8 level3", model(cur_el, cv));
      end
    end

    // Back-to-back requests and one-cycle latency (R2)
    cur_el = 2'd1; cv = 11'h7FF; req_valid = 1'b1;
    @(negedge clk);
    check("R2 first of pair", model(cur_el, cv));
    cur_el = 2'd3; cv = 11'h7DF;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 second of pair", model(cur_el, cv));
    @(negedge clk);
    check("R2 idle after pair", 13'h0);

    // Encoding near-misses and no strobe (R1)
    for (int b = 0; b < 16; b++) begin
      set_enc(ENC_OK ^ (16'h1 << b));
      cur_el = 2'd1; cv = 11'h7FF; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R1 encoding miss", 13'h0);
    end
    set_enc(ENC_OK);
    req_valid = 1'b0;
    @(negedge clk);
    check("R1 no strobe", 13'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule